// File: doc/BRIEF.md
# Watchdog Timer with Deferred Enable

This block is a supervision counter that asks for a reset of the whole controller when software stops servicing it. A free-running 16-bit count advances on each state-time tick while the watchdog is armed. If the count passes its top value before software services it, the block raises a one-cycle reset request and starts again from zero. To service it, software writes a two-byte unlock sequence to the block's write port, and the count drops back to zero.

A configuration bit is captured while the system reset is held. With the bit low, the watchdog is armed as soon as reset ends. With the bit high, it stays dormant after reset and arms on the first valid service sequence. Once armed, nothing but a reset disarms it. Changing the configuration input at run time has no effect.

Top module: `wdt_deferred`

## Requirements
- R1: While armed, the count advances by exactly one on each clock edge where `tick` is 1, and holds on edges where `tick` is 0.
- R2: The 65536th counted tick after the count was last zero raises `wdt_rst_req` to 1 for exactly one cycle, in the cycle right after that tick's edge. The count then continues from zero, so the next request follows 65536 ticks later.
- R3: If `cfg_defer` is 0 during reset, the watchdog is armed from the first cycle after reset, with the count at zero.
- R4: If `cfg_defer` is 1 during reset, the watchdog is dormant. No tick is counted and no request is raised, however many ticks arrive.
- R5: A valid service is a write (`wr_stb` = 1) of 8'h1E followed by the next write carrying 8'hE1. Cycles without a write may sit between the two. The service zeroes the count on the edge of the 8'hE1 write. If a tick comes in the same cycle, the service wins and no request is raised.
- R6: Any other write sequence has no effect on the count. This covers 8'hE1 without a directly preceding 8'h1E write, and a 8'h1E write followed by a write of another value and then 8'hE1.
- R7: A dormant watchdog arms on the first valid service. Invalid sequences leave it dormant.
- R8: Once armed, the watchdog stays armed through its own reset request and through any writes. Only `rst` returns it to its after-reset state.
- R9: `cfg_defer` is sampled only while `rst` is 1. Changes after reset are ignored.
- R10: `rst` is synchronous and active high. While it is asserted, and in the cycle after it, `wdt_rst_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures `cfg_defer` |
| tick | input | 1 | One-cycle strobe per state time |
| wr_stb | input | 1 | Software write strobe for the service sequence |
| wr_data | input | 8 | Byte written with `wr_stb` |
| cfg_defer | input | 1 | 1 = dormant until first service, 0 = armed from reset |
| wdt_rst_req | output | 1 | Registered one-cycle reset request |

## Verification
The hardest case to reach is one that takes a full 65536-tick window before anything shows at the output. That window is needed to see that a dormant watchdog never fires, that an armed one fires again after its own request, and that a service on the very last tick holds the request off. The bench drives two instances with the same tick stream, one configured to arm at reset and one configured as dormant. Three back-to-back windows then cover every case: the dormant one's silence, its arming, its first request, the early one's two requests, and the last-tick service. Broken unlock sequences are placed early in a window, so that a wrongly accepted one would move the next request to a cycle the reference model does not expect.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WDT_CNT_W = 16;
  localparam int WDT_KEY_W = 8;
  localparam logic [WDT_KEY_W-1:0] WDT_KEY_FIRST  = 8'h1E;
  localparam logic [WDT_KEY_W-1:0] WDT_KEY_SECOND = 8'hE1;

  typedef enum logic [0:0] {
    KEY_WAIT = 1'b0,
    KEY_HALF = 1'b1
  } key_state_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int                KEY_W      = WDT_KEY_W,
  parameter logic [KEY_W-1:0]  KEY_FIRST  = WDT_KEY_FIRST,
  parameter logic [KEY_W-1:0]  KEY_SECOND = WDT_KEY_SECOND
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [KEY_W-1:0] wr_data,
  output logic             clr_hit
);
  key_state_e st_q;
  logic       is_first;
  logic       is_second;

  always_comb begin
    is_first  = wr_stb && (wr_data == KEY_FIRST);
    is_second = wr_stb && (wr_data == KEY_SECOND);
    clr_hit   = is_second && (st_q == KEY_HALF);
  end

  // Every write decides the stage anew; idle cycles keep it.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KEY_WAIT;
    end else if (wr_stb) begin
      st_q <= is_first ? KEY_HALF : KEY_WAIT;
    end
  end

  // R6
  seq_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> (st_q == KEY_WAIT));

  // R5
  half_needs_first_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == KEY_HALF) |-> $past(st_q == KEY_HALF || is_first));
endmodule

// File: rtl/wdt_arm.sv
module wdt_arm (
  input  logic clk,
  input  logic rst,
  input  logic cfg_defer,
  input  logic clr_hit,
  output logic active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= ~cfg_defer;
    end else if (clr_hit) begin
      active <= 1'b1;
    end
  end

  // R8
  arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    active |=> active);

  // R3
  arm_from_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (active == !$past(cfg_defer)));

  // R7
  wake_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && clr_hit) |=> active);
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int CNT_W = WDT_CNT_W
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic clr,
  output logic req
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             at_top;

  always_comb at_top = (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      req   <= 1'b0;
    end else begin
      req <= 1'b0;
      if (clr) begin
        cnt_q <= '0;
      end else if (en && tick) begin
        if (at_top) begin
          cnt_q <= '0;
          req   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);

  // R1
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !clr && !at_top) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt_q));

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> ((cnt_q == '0) && !req));

  // R4
  req_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(en));
endmodule

// File: rtl/wdt_deferred.sv
module wdt_deferred
  import wdt_pkg::*;
#(
  parameter int               CNT_W      = WDT_CNT_W,
  parameter int               KEY_W      = WDT_KEY_W,
  parameter logic [KEY_W-1:0] KEY_FIRST  = WDT_KEY_FIRST,
  parameter logic [KEY_W-1:0] KEY_SECOND = WDT_KEY_SECOND
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_stb,
  input  logic [KEY_W-1:0] wr_data,
  input  logic             cfg_defer,
  output logic             wdt_rst_req
);
  logic clr_hit;
  logic active;

  wdt_key_seq #(
    .KEY_W      (KEY_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_key (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .clr_hit (clr_hit)
  );

  wdt_arm u_arm (
    .clk       (clk),
    .rst       (rst),
    .cfg_defer (cfg_defer),
    .clr_hit   (clr_hit),
    .active    (active)
  );

  wdt_count #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .en   (active),
    .tick (tick),
    .clr  (clr_hit),
    .req  (wdt_rst_req)
  );

  // R4
  req_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |-> active);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !wdt_rst_req);
endmodule

// File: tb/wdt_deferred_tb.sv
module wdt_ref_model #(
  parameter int unsigned LIMIT = 65536
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       cfg,
  output logic       exp_req
);
  int unsigned ticks;
  bit          armed;
  bit          saw_first;
  bit          good;

  initial begin
    exp_req   = 1'b0;
    ticks     = 0;
    armed     = 1'b0;
    saw_first = 1'b0;
  end

  always @(posedge clk) begin
    if (rst) begin
      armed     = !cfg;
      ticks     = 0;
      saw_first = 1'b0;
      exp_req  <= 1'b0;
    end else begin
      good = wr_stb && (wr_data == 8'hE1) && saw_first;
      if (wr_stb) saw_first = (wr_data == 8'h1E);
      exp_req <= 1'b0;
      if (good) begin
        armed = 1'b1;
        ticks = 0;
      end else if (armed && tick) begin
        ticks = ticks + 1;
        if (ticks == LIMIT) begin
          ticks = 0;
          exp_req <= 1'b1;
        end
      end
    end
  end
endmodule

module wdt_deferred_tb;
  localparam int LAST_CYC  = 196650;
  localparam int WDOG_LIM  = 199000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       a_wr = 1'b0, b_wr = 1'b0;
  logic [7:0] a_dat = 8'h00, b_dat = 8'h00;
  logic       a_cfg = 1'b0, b_cfg = 1'b1;
  logic       a_req, b_req, a_exp, b_exp;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    cmp_on = 1'b0;
  bit    finished = 1'b0;
  string tag_a = "R3";
  string tag_b = "R4";

  always #4 clk = ~clk;

  wdt_deferred u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_stb(a_wr), .wr_data(a_dat),
    .cfg_defer(a_cfg), .wdt_rst_req(a_req)
  );

  wdt_deferred u_dorm (
    .clk(clk), .rst(rst), .tick(tick), .wr_stb(b_wr), .wr_data(b_dat),
    .cfg_defer(b_cfg), .wdt_rst_req(b_req)
  );

  wdt_ref_model u_ref_a (
    .clk(clk), .rst(rst), .tick(tick), .wr_stb(a_wr), .wr_data(a_dat),
    .cfg(a_cfg), .exp_req(a_exp)
  );

  wdt_ref_model u_ref_b (
    .clk(clk), .rst(rst), .tick(tick), .wr_stb(b_wr), .wr_data(b_dat),
    .cfg(b_cfg), .exp_req(b_exp)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk(tag_a, a_req, a_exp);
      chk(tag_b, b_req, b_exp);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIM && !finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog: actual %0d cycles expected below %0d", cyc, WDOG_LIM);
      finish_run();
    end
  end

  task automatic drive(input int c);
    tick  = (c >= 5);
    a_wr  = 1'b0;
    a_dat = 8'h00;
    b_wr  = 1'b0;
    b_dat = 8'h00;
    if (c == 0) begin
      a_cfg = 1'b1;  // R9: late change must be ignored
      b_cfg = 1'b0;
    end
    case (c)
      100:    begin a_wr = 1'b1; a_dat = 8'h1E; end
      101:    begin a_wr = 1'b1; a_dat = 8'h00; end
      102:    begin a_wr = 1'b1; a_dat = 8'hE1; end
      200:    begin a_wr = 1'b1; a_dat = 8'hE1; end
      196611: begin a_wr = 1'b1; a_dat = 8'h1E; end
      196612: begin a_wr = 1'b1; a_dat = 8'hE1; end
      default: ;
    endcase
    case (c)
      50:     begin b_wr = 1'b1; b_dat = 8'hE1; end
      70:     begin b_wr = 1'b1; b_dat = 8'h1E; end
      71:     begin b_wr = 1'b1; b_dat = 8'h33; end
      72:     begin b_wr = 1'b1; b_dat = 8'hE1; end
      66000:  begin b_wr = 1'b1; b_dat = 8'h1E; end
      66004:  begin b_wr = 1'b1; b_dat = 8'hE1; end
      default: ;
    endcase
    if (c == 65541) tag_a = "R8";
    if (c == 196000) tag_a = "R5";
    if (c == 66004) tag_b = "R7";
  endtask

  task automatic probe(input int c);
    case (c)
      0:      begin chk("R10 after reset", a_req, 1'b0); chk("R10 after reset", b_req, 1'b0); end
      60:     chk("R6 lone second key", b_req, 1'b0);
      65539:  chk("R2 not early", a_req, 1'b0);
      65540:  begin
                chk("R1 R3 first overflow at tick 65536", a_req, 1'b1);
                chk("R4 dormant ignores ticks", b_req, 1'b0);
                chk("R9 dormant cfg ignored", b_req, 1'b0);
              end
      65541:  chk("R2 single cycle pulse", a_req, 1'b0);
      65608:  chk("R7 broken key left dormant", b_req, 1'b0);
      66000:  chk("R6 broken key kept count", a_req, 1'b0);
      131075: chk("R8 not early after request", a_req, 1'b0);
      131076: chk("R8 R2 second overflow after restart", a_req, 1'b1);
      131077: chk("R2 second pulse single cycle", a_req, 1'b0);
      131539: chk("R7 not early", b_req, 1'b0);
      131540: chk("R7 R5 armed by gapped key, overflow", b_req, 1'b1);
      131541: chk("R2 armed pulse single cycle", b_req, 1'b0);
      196612: chk("R5 clear on last tick wins", a_req, 1'b0);
      196613: chk("R5 no late request", a_req, 1'b0);
      default: ;
    endcase
  endtask

  initial begin
    rst   = 1'b1;
    a_cfg = 1'b0;
    b_cfg = 1'b1;
    repeat (3) @(negedge clk);
    cmp_on = 1'b1;
    chk("R10 during reset", a_req, 1'b0);
    chk("R10 during reset", b_req, 1'b0);
    rst = 1'b0;
    for (int c = 0; c <= LAST_CYC; c++) begin
      drive(c);
      @(negedge clk);
      probe(c);
    end
    finish_run();
  end
endmodule